// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits between the decoded byte-write events of a parallel EEPROM (one strobe carrying a 17-bit address and an 8-bit data byte) and the logic that enables writes into the array. It watches for fixed address/data command sequences. One sequence switches software write protection on. Another switches it off. It decides for each incoming write whether the array may take it, and it issues a one-cycle start to the internal write timer when a page of writes closes.

The three-write unlock pattern does two jobs. It requests protection, and it authorises the page write that follows it. Protection takes effect only when the write timer for that page has run out. While protected, a write that is not preceded by the unlock pattern is not stored, but it still opens a page and runs the write timer, so a host cannot tell from timing that the write was refused. The protection state survives the block reset, as a non-volatile bit would.

A page collects writes until `PAGE_BYTES` writes have been taken or until `GAP_CYC` cycles pass with no write. The write timer then runs for `TWC_CYC` cycles. Writes that arrive during that time are dropped.

Top module: `swprot_seq`

## Requirements
- R1: While unprotected and with no sequence in progress, a write that is not a sequence step raises `arr_we` in the same cycle as `wr_en`. `arr_we` is never high without `wr_en`.
- R2: A page closes once `GAP_CYC` cycles pass with no write after its last write. `tmr_start` is then high for exactly one cycle, `GAP_CYC`+1 cycles after the cycle of that last write.
- R3: A page also closes on its `PAGE_BYTES`-th write. `tmr_start` is then high in the cycle after that write.
- R4: Three sequence writes arm protection: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. None of the three reaches the array. They open an authorised page. `prot` rises `TWC_CYC` cycles after that page's `tmr_start` pulse and not before.
- R5: While protected, a write that is not preceded by the arm sequence leaves `arr_we` low. It still opens a page, and that page produces a `tmr_start` pulse.
- R6: While protected, the arm sequence followed by page writes stores those writes (`arr_we` high), and `prot` stays high.
- R7: Asserting `rst` does not change `prot`.
- R8: Six sequence writes disarm protection: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. `prot` is low in the cycle after the sixth write. None of the six is stored, and none produces `tmr_start`.
- R9: A write that departs from the expected step returns the matcher to idle and is handled as an ordinary write. The one exception is 0xAA@0x5555, which restarts the sequence at step one. The sequence writes that came before are not stored.
- R10: Command matching compares only address bits 14..0. Bit 16 is ignored, and a change in bit 14 breaks a match.
- R11: While the write timer runs (for `TWC_CYC` cycles from the `tmr_start` pulse), writes are dropped. They cause no `arr_we` and no further `tmr_start`.
- R12: Under `rst`, `arr_we` and `tmr_start` are low, and any partial sequence progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; leaves `prot` alone |
| wr_en | input | 1 | One decoded write event this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| arr_we | output | 1 | Array write enable for the current write (combinational) |
| tmr_start | output | 1 | One-cycle start of the internal write timer |
| prot | output | 1 | Software write protection active |

## Verification
`arr_we` is due in the same cycle as the write. The bench drives inputs just after a falling edge and reads `arr_we` a moment later, before the next rising edge. `tmr_start` is due `GAP_CYC`+1 cycles after a page's last write, or 1 cycle after a filling write. The bench keeps a count of rising edges, notes the edge number at which each pulse was seen, and compares it with the number worked out from the cycle of the write. `prot` is due `TWC_CYC` cycles after the pulse when arming, and 1 cycle after the last write when disarming. Both edges are checked on the exact cycle, and on the cycle just before for the rise, using a small configuration (4-byte pages, 3-cycle gap, 5-cycle timer). That configuration lets every data value at the first command address be swept.

// File: rtl/swprot_seq.sv
module swprot_seq #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MATCH_W    = 15,
  parameter int PAGE_BYTES = 128,
  parameter int GAP_CYC    = 16,
  parameter int TWC_CYC    = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              arr_we,
  output logic              tmr_start,
  output logic              prot
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int TWC_W = $clog2(TWC_CYC + 1);
  localparam logic [CNT_W-1:0] PAGE_FULL = CNT_W'(PAGE_BYTES);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_CYC - 1);
  localparam logic [TWC_W-1:0] TWC_LAST  = TWC_W'(TWC_CYC - 1);
  localparam logic [MATCH_W-1:0] ADR_HI  = MATCH_W'(15'h5555);
  localparam logic [MATCH_W-1:0] ADR_LO  = MATCH_W'(15'h2AAA);

  localparam logic [1:0] S_IDLE = 2'd0, S_PAGE = 2'd1, S_BUSY = 2'd2;

  logic [1:0]       st_q, st_d;
  logic [2:0]       step_q, step_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_n;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [TWC_W-1:0] twc_q, twc_d;
  logic             auth_q, auth_d, armp_q, armp_d, ts_q, ts_d;
  logic             prot_q = 1'b0;
  logic             prot_d, we, page_wr;

  wire [MATCH_W-1:0] madr = wr_addr[MATCH_W-1:0];
  wire at_hi  = madr == ADR_HI;
  wire at_lo  = madr == ADR_LO;
  wire first  = at_hi && wr_data == 8'hAA;
  wire arm    = step_q == 3'd2 && at_hi && wr_data == 8'hA0;

  logic adv;
  always_comb begin
    case (step_q)
      3'd0:    adv = first;
      3'd1:    adv = at_lo && wr_data == 8'h55;
      3'd2:    adv = at_hi && wr_data == 8'h80;
      3'd3:    adv = first;
      3'd4:    adv = at_lo && wr_data == 8'h55;
      3'd5:    adv = at_hi && wr_data == 8'h20;
      default: adv = 1'b0;
    endcase
  end

  assign cnt_n = (st_q == S_IDLE ? '0 : cnt_q) + 1'b1;

  always_comb begin
    st_d = st_q;  step_d = step_q; cnt_d = cnt_q; gap_d = gap_q;
    twc_d = twc_q; auth_d = auth_q; armp_d = armp_q; ts_d = 1'b0;
    prot_d = prot_q; we = 1'b0; page_wr = 1'b0;
    case (st_q)
      S_IDLE: if (wr_en) begin
        if (arm) begin
          st_d = S_PAGE; cnt_d = '0; gap_d = '0;
          auth_d = 1'b1; armp_d = 1'b1; step_d = '0;
        end else if (adv) begin
          if (step_q == 3'd5) begin
            prot_d = 1'b0; step_d = '0;
          end else
            step_d = step_q + 1'b1;
        end else if (first)
          step_d = 3'd1;
        else begin
          step_d = '0; auth_d = !prot_q; we = !prot_q; page_wr = 1'b1;
        end
      end
      S_PAGE: if (wr_en) begin
        we = auth_q; page_wr = 1'b1;
      end else if (gap_q == GAP_LAST) begin
        st_d = S_BUSY; ts_d = 1'b1; twc_d = TWC_LAST;
      end else
        gap_d = gap_q + 1'b1;
      S_BUSY: if (twc_q == '0) begin
        st_d = S_IDLE; prot_d = prot_q | armp_q; armp_d = 1'b0;
      end else
        twc_d = twc_q - 1'b1;
      default: st_d = S_IDLE;
    endcase
    if (page_wr) begin
      if (cnt_n == PAGE_FULL) begin
        st_d = S_BUSY; ts_d = 1'b1; twc_d = TWC_LAST;
      end else begin
        st_d = S_PAGE; cnt_d = cnt_n; gap_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; step_q <= '0; cnt_q <= '0; gap_q <= '0; twc_q <= '0;
      auth_q <= 1'b0; armp_q <= 1'b0; ts_q <= 1'b0;
    end else begin
      st_q <= st_d; step_q <= step_d; cnt_q <= cnt_d; gap_q <= gap_d;
      twc_q <= twc_d; auth_q <= auth_d; armp_q <= armp_d; ts_q <= ts_d;
    end
  end

  always_ff @(posedge clk)
    if (!rst) prot_q <= prot_d;

  assign arr_we    = we & ~rst;
  assign tmr_start = ts_q;
  assign prot      = prot_q;
endmodule

module swprot_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       arr_we,
  input logic       tmr_start,
  input logic       prot,
  input logic [1:0] st
);
  assert_we_needs_write_R1: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> wr_en);
  assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    tmr_start |=> !tmr_start);
  assert_start_enters_busy_R3: assert property (@(posedge clk) disable iff (rst)
    tmr_start |-> st == 2'd2);
  assert_prot_rise_after_timer_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(prot) |-> ($past(st) == 2'd2 && st == 2'd0));
  assert_prot_fall_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(prot) |-> $past(wr_en));
  assert_busy_drops_writes_R11: assert property (@(posedge clk) disable iff (rst)
    st == 2'd2 |-> !arr_we);
endmodule

bind swprot_seq swprot_seq_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .arr_we(arr_we),
  .tmr_start(tmr_start), .prot(prot), .st(st_q)
);

// File: tb/swprot_seq_tb_top.sv
`timescale 1ns/1ps
module swprot_seq_tb_top;
  localparam int PB = 4, GAP = 3, TWC = 5, LONG = GAP + TWC + 3;
  localparam logic [16:0] AH = 17'h05555, AL = 17'h02AAA;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic arr_we, tmr_start, prot;
  int cyc = 0, tcount = 0, tlast = -1, nchk = 0, nfail = 0, lastw = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (tmr_start) begin tcount++; tlast = cyc; end

  swprot_seq #(.PAGE_BYTES(PB), .GAP_CYC(GAP), .TWC_CYC(TWC)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arr_we(arr_we), .tmr_start(tmr_start), .prot(prot));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit exp_we, input string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d; lastw = cyc;
    #1 chk(arr_we == exp_we, req, arr_we, exp_we);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_cyc(input int x);
    while (cyc < x) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int t0, tt, m;
    idle(3);
    #1;
    chk(arr_we == 0, "R12 we in reset", arr_we, 0);
    chk(tmr_start == 0, "R12 start in reset", tmr_start, 0);
    chk(prot == 0, "R12 prot power-on", prot, 0);
    @(negedge clk); rst = 1'b0;

    // R1/R2 sweep of every data value at the first command address
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hAA) continue;
      t0 = tcount;
      wr(AH, 8'(d), 1'b1, "R1 ordinary write");
      tt = lastw + 1 + GAP;
      idle(LONG);
      chk(tcount == t0 + 1, "R2 one pulse", tcount - t0, 1);
      chk(tlast == tt, "R2 pulse cycle", tlast, tt);
    end

    // R3 page closes on its last byte
    t0 = tcount;
    for (int i = 0; i < PB; i++) wr(17'h00100 + 17'(i), 8'(i), 1'b1, "R3 page byte");
    tt = lastw + 1;
    idle(LONG);
    chk(tlast == tt, "R3 full page pulse cycle", tlast, tt);
    chk(tcount == t0 + 1, "R3 one pulse", tcount - t0, 1);

    // R11 writes during timer dropped
    t0 = tcount;
    wr(17'h00200, 8'h11, 1'b1, "R11 setup write");
    tt = lastw + 1 + GAP;
    wait_cyc(tt + 1);
    wr(17'h00201, 8'h77, 1'b0, "R11 write while busy");
    idle(LONG);
    chk(tcount == t0 + 1, "R11 no extra pulse", tcount - t0, 1);

    // R9 mismatch handled as ordinary, prefix not stored
    wr(AH, 8'hAA, 1'b0, "R9 step one swallowed");
    wr(AL, 8'h55, 1'b0, "R9 step two swallowed");
    wr(AH, 8'h33, 1'b1, "R9 mismatch stored");
    idle(LONG);
    wr(AH, 8'hAA, 1'b0, "R9 step one");
    wr(AH, 8'hAA, 1'b0, "R9 restart swallowed");
    wr(AL, 8'h55, 1'b0, "R9 step two after restart");
    wr(AH, 8'h44, 1'b1, "R9 mismatch after restart");
    idle(LONG);
    chk(prot == 0, "R9 still unprotected", prot, 0);

    // R12 reset discards progress
    wr(AH, 8'hAA, 1'b0, "R12 step one");
    wr(AL, 8'h55, 1'b0, "R12 step two");
    rst = 1'b1; idle(2); rst = 1'b0;
    wr(AH, 8'hA0, 1'b1, "R12 progress cleared, stored");
    idle(LONG);
    chk(prot == 0, "R12 no arming", prot, 0);

    // R10 bit 14 breaks match
    wr(17'h01555, 8'hAA, 1'b1, "R10 bit14 differs stored");
    idle(LONG);

    // R4 arm with bit 16 set in addresses
    t0 = tcount;
    wr(17'h15555, 8'hAA, 1'b0, "R4/R10 arm step one");
    wr(17'h12AAA, 8'h55, 1'b0, "R4/R10 arm step two");
    wr(17'h15555, 8'hA0, 1'b0, "R4/R10 arm step three");
    wr(17'h00300, 8'h01, 1'b1, "R4 page byte");
    wr(17'h00301, 8'h02, 1'b1, "R4 page byte");
    tt = lastw + 1 + GAP;
    wait_cyc(tt);
    chk(tlast == tt, "R4 page pulse cycle", tlast, tt);
    wait_cyc(tt + TWC - 1);
    chk(prot == 0, "R4 prot not early", prot, 0);
    wait_cyc(tt + TWC);
    chk(prot == 1, "R4 prot rises", prot, 1);
    idle(2);

    // R5 unauthorised write
    t0 = tcount;
    wr(17'h00400, 8'h5A, 1'b0, "R5 blocked write");
    tt = lastw + 1 + GAP;
    idle(LONG);
    chk(tlast == tt, "R5 timer still runs", tlast, tt);
    chk(tcount == t0 + 1, "R5 one pulse", tcount - t0, 1);
    chk(prot == 1, "R5 prot kept", prot, 1);

    // R7 reset keeps protection
    rst = 1'b1; idle(2); rst = 1'b0;
    #1 chk(prot == 1, "R7 prot after reset", prot, 1);
    idle(1);

    // R6 authorised full page while protected
    wr(AH, 8'hAA, 1'b0, "R6 step one");
    wr(AL, 8'h55, 1'b0, "R6 step two");
    wr(AH, 8'hA0, 1'b0, "R6 step three");
    for (int i = 0; i < PB; i++) wr(17'h00500 + 17'(i), 8'(i + 9), 1'b1, "R6 page byte stored");
    tt = lastw + 1;
    idle(LONG);
    chk(tlast == tt, "R6 pulse cycle", tlast, tt);
    chk(prot == 1, "R6 prot kept", prot, 1);

    // R8 disarm
    t0 = tcount;
    wr(AH, 8'hAA, 1'b0, "R8 step1");
    wr(AL, 8'h55, 1'b0, "R8 step2");
    wr(AH, 8'h80, 1'b0, "R8 step3");
    wr(AH, 8'hAA, 1'b0, "R8 step4");
    wr(AL, 8'h55, 1'b0, "R8 step5");
    m = cyc;
    chk(prot == 1, "R8 prot before last", prot, 1);
    wr(AH, 8'h20, 1'b0, "R8 step6");
    #1 chk(prot == 0 && cyc == m + 1, "R8 prot cleared", prot, 0);
    idle(LONG);
    chk(tcount == t0, "R8 no timer", tcount - t0, 0);
    wr(17'h00600, 8'h99, 1'b1, "R1 write after disarm");
    idle(LONG);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule